// File: doc/BRIEF.md
# Claim-Complete Platform Interrupt Controller

This block collects level interrupt requests from `NUM_SRC` sources and signals a single hart through one interrupt line. Each source has a 3-bit priority, an enable bit and a pending bit. The controller also holds one global priority threshold. The line is raised whenever an enabled pending source has a priority strictly above the threshold.

Software services an interrupt in two register accesses. First it reads the claim register, which returns the winning source ID and takes that source out of arbitration. When the handler is done, it writes the same ID back to the claim register. Between these two accesses the source is marked as in service, and a request arriving on its line cannot make it pending again. Arbitration is combinational over the stored state, so every claim, completion, priority, enable or threshold write is reflected on the interrupt line in the cycle after the access.

Register access uses a simple port: valid, write, word address and write data. Read data comes back one cycle after the request, together with a response valid. The word address map is as follows:

- Priorities: word `k`, for `k` below `NUM_SRC`, holds the priority of source `k+1`.
- Pending words: base 64.
- Enable words: base 96.
- Threshold: word 126.
- Claim/complete: word 127.

Top module: `claim_intc`

## Requirements
- R1: After reset all pending bits, in-service flags, enables, priorities and the threshold are zero, and `irq_o` is low.
- R2: A high request on a source that is not in service sets its pending bit at the next clock edge. Pending word `w` (address 64+w) shows source n at word n/32, bit n%32.
- R3: While a source is in service, a request on its line does not set its pending bit.
- R4: The winner is the enabled pending source whose priority is strictly greater than the threshold and greater than that of every other such source. On equal priority the lowest ID wins. The winner follows any priority or threshold write from the next cycle.
- R5: Source ID 0 is reserved. `irq_o` is high exactly when a nonzero winner exists.
- R6: A priority write stores only data bits [2:0]. Word offset k addresses source k+1.
- R7: A read of address 127 returns the current winner. The same read clears that source's pending bit and marks it in service, and the next winner takes effect from the following cycle.
- R8: A read of address 127 with no winner returns 0 and changes no pending or in-service state.
- R9: A write of ID v to address 127 ends service for source v if it is in service. A write with v = 0, v > NUM_SRC, or v not in service has no effect.
- R10: Enable word w (address 96+w) uses the same packing as the pending words. A disabled source keeps its pending bit but never wins.
- R11: Every read request produces `rsp_valid_o` high with its data on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level requests; bit n is source n (bits NUM_SRC down to 1) |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 7 | Word address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt line to the hart |

## Verification
A corrupted in-service flag shows up in one of two ways. Either a request is silently dropped, which is visible in the pending word at the next read, or a source is claimed twice. A wrong priority compare or tie-break shows up as the wrong ID on the very next claim read. Because arbitration is combinational over the registered state, a stale winner shows as a mismatch between `irq_o` and the claim result within one cycle of the access that should have changed it. The bench therefore reads the pending words, `irq_o` and the claim register directly after every state-changing access.

// File: rtl/claim_intc.sv
module claim_intc #(
  parameter int NUM_SRC = 40,
  parameter int PRIO_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC:1]  src_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [6:0]        req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              irq_o
);
  localparam int NW         = (NUM_SRC + 32) / 32;
  localparam int TOT        = NW * 32;
  localparam int ID_W       = $clog2(NUM_SRC + 1);
  localparam int PEND_BASE  = 64;
  localparam int EN_BASE    = 96;
  localparam int THR_ADDR   = 126;
  localparam int CLAIM_ADDR = 127;

  logic [TOT-1:0]    pend, claimed, en, src_ext, valid_m, clr_vec, cmp_vec;
  logic [PRIO_W-1:0] prio [NUM_SRC:1];
  logic [PRIO_W-1:0] thr, best;
  logic [ID_W-1:0]   win;
  logic [31:0]       rd_mux;
  logic              wr, rd, take, cmp_ok;

  assign src_ext = TOT'({src_i, 1'b0});
  assign valid_m = TOT'({{NUM_SRC{1'b1}}, 1'b0});
  assign wr      = req_valid_i & req_write_i;
  assign rd      = req_valid_i & ~req_write_i;

  always_comb begin
    best = thr;
    win  = '0;
    for (int i = 1; i <= NUM_SRC; i++)
      if (pend[i] && en[i] && prio[i] > best) begin
        best = prio[i];
        win  = ID_W'(i);
      end
  end

  assign irq_o   = (win != '0);
  assign take    = rd && int'(req_addr_i) == CLAIM_ADDR && irq_o;
  assign cmp_ok  = wr && int'(req_addr_i) == CLAIM_ADDR &&
                   req_wdata_i != 32'd0 && req_wdata_i <= 32'(NUM_SRC);
  assign clr_vec = take   ? (TOT'(1) << win) : '0;
  assign cmp_vec = cmp_ok ? (TOT'(1) << req_wdata_i[ID_W-1:0]) : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend    <= '0;
      claimed <= '0;
    end else begin
      pend    <= (pend | (src_ext & ~claimed)) & ~clr_vec & valid_m;
      claimed <= (claimed | clr_vec) & ~cmp_vec;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en  <= '0;
      thr <= '0;
      for (int k = 1; k <= NUM_SRC; k++) prio[k] <= '0;
    end else if (wr) begin
      for (int w = 0; w < NW; w++)
        if (int'(req_addr_i) == EN_BASE + w)
          en[w*32 +: 32] <= req_wdata_i & valid_m[w*32 +: 32];
      for (int k = 0; k < NUM_SRC; k++)
        if (int'(req_addr_i) == k) prio[k+1] <= req_wdata_i[PRIO_W-1:0];
      if (int'(req_addr_i) == THR_ADDR) thr <= req_wdata_i[PRIO_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_SRC; k++)
      if (int'(req_addr_i) == k) rd_mux = 32'(prio[k+1]);
    for (int w = 0; w < NW; w++) begin
      if (int'(req_addr_i) == PEND_BASE + w) rd_mux = pend[w*32 +: 32];
      if (int'(req_addr_i) == EN_BASE + w)   rd_mux = en[w*32 +: 32];
    end
    if (int'(req_addr_i) == THR_ADDR)   rd_mux = 32'(thr);
    if (int'(req_addr_i) == CLAIM_ADDR) rd_mux = 32'(win);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd;
      rsp_rdata_o <= rd ? rd_mux : '0;
    end
  end

  assert_no_pend_while_claimed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((pend & ~$past(pend) & $past(claimed)) == '0));

  assert_claim_marks_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (claimed[$past(win)] && !pend[$past(win)]));

  assert_flag_only_by_claim_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((claimed & ~$past(claimed)) == '0 || $past(take)));

  assert_irq_source_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend[win] && en[win] && !claimed[win]));

  assert_rsp_after_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (rsp_valid_o == $past(rd)));
endmodule

// File: tb/claim_intc_tb.sv
module claim_intc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 40;
  localparam int CLM = 127;
  localparam int THR = 126;
  localparam int PND = 64;
  localparam int ENA = 96;
  localparam int NV = 6;
  localparam logic [NS:0] VEC_SRC [NV] = '{
    41'h2, 41'h24, 41'h80_0000_0020, 41'h2_0000_0004, 41'h180_0000_0000, 41'h102_0000_0004};
  localparam int VEC_ID [NV] = '{0, 2, 5, 33, 39, 33};

  logic clk = 0, rst_n = 0;
  logic [NS:1] src = '0;
  logic req_valid = 0, req_write = 0;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata, d;
  logic rsp_valid, irq;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  claim_intc u_dut (.clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_valid_i(req_valid),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = 7'(a); req_wdata = v;
    @(negedge clk); req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = 7'(a);
    @(negedge clk); req_valid = 0;
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd1);
    v = rsp_rdata;
  endtask

  task automatic pulse(input logic [NS:0] v);
    @(negedge clk); src = v[NS:1];
    @(negedge clk); src = '0;
  endtask

  task automatic drain();
    logic [31:0] x;
    for (int n = 0; n < NS + 2; n++) begin
      rd(CLM, x);
      if (x == 0) break;
      wr(CLM, x);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq after reset", 32'(irq), 0);
    rd(PND, d);      chk("R1 pending word0", d, 0);
    rd(4, d);        chk("R1 priority", d, 0);
    rd(THR, d);      chk("R1 threshold", d, 0);
    rd(ENA + 1, d);  chk("R1 enable word1", d, 0);

    wr(2, 32'hFF);
    rd(2, d);        chk("R6 priority low bits", d, 7);

    wr(0, 1); wr(1, 3); wr(4, 3); wr(32, 5); wr(38, 2); wr(39, 7);
    wr(THR, 1);
    wr(ENA, 32'h26); wr(ENA + 1, 32'h82);
    rd(ENA, d);      chk("R10 enable word0", d, 32'h26);

    rd(CLM, d);      chk("R8 empty claim", d, 0);

    pulse(41'h100_0000_0000);
    rd(PND + 1, d);  chk("R2 packing source 40", d, 32'h100);
    chk("R10 disabled no irq", 32'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      pulse(VEC_SRC[i]);
      chk("R5 irq level", 32'(irq), 32'(VEC_ID[i] != 0));
      rd(CLM, d);    chk("R4 winner", d, 32'(VEC_ID[i]));
      if (d != 0) wr(CLM, d);
      drain();
    end
    rd(PND, d);      chk("R10 low prio stays pending", d, 32'h2);

    @(negedge clk); src[2] = 1;
    rd(CLM, d);      chk("R7 claim id", d, 2);
    rd(PND, d);      chk("R3 blocked while claimed", d, 32'h2);
    wr(CLM, 2);
    @(negedge clk);
    rd(PND, d);      chk("R9 repend after complete", d, 32'h6);
    chk("R5 irq after repend", 32'(irq), 1);
    src = '0;
    rd(CLM, d);      chk("R7 reclaim", d, 2);
    wr(CLM, 2);

    pulse(41'h20);
    rd(CLM, d);      chk("R7 claim 5", d, 5);
    wr(CLM, 99);
    wr(CLM, 0);
    pulse(41'h20);
    rd(PND, d);      chk("R9 bad id ignored", d, 32'h2);
    wr(CLM, 5);
    pulse(41'h20);
    rd(PND, d);      chk("R9 completed repends", d, 32'h22);
    rd(CLM, d);      chk("R4 claim 5", d, 5);
    wr(CLM, 5);

    pulse(41'h2_0000_0000);
    chk("R5 irq with 33", 32'(irq), 1);
    wr(THR, 7);
    chk("R4 threshold masks", 32'(irq), 0);
    rd(CLM, d);      chk("R8 masked claim", d, 0);
    rd(PND + 1, d);  chk("R8 no state change", d, 32'h102);
    wr(THR, 1);
    chk("R4 threshold lowered", 32'(irq), 1);
    rd(CLM, d);      chk("R7 claim 33", d, 33);
    chk("R7 irq drops", 32'(irq), 0);
    wr(CLM, 33);

    pulse(41'h24);
    rd(CLM, d);      chk("R4 tie lowest id", d, 2);
    chk("R7 next winner live", 32'(irq), 1);
    rd(CLM, d);      chk("R7 second claim", d, 5);
    chk("R7 irq after both", 32'(irq), 0);
    wr(CLM, 2); wr(CLM, 5);

    pulse(41'h24);
    wr(4, 4);
    rd(CLM, d);      chk("R6 priority rewrite rearbitrates", d, 5);
    wr(CLM, 5);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule